// File: doc/BRIEF.md
# Descriptor Chain Transmit DMA Engine

This engine takes the pointer to a packet descriptor from a transmit queue and fetches the descriptor from a word-addressed memory. It then follows the linked list of buffer descriptors that hang off it and sends the bytes of each buffer, in chain order, on a byte-wide valid/ready stream. Once descriptors are finished with, it pushes their pointers onto return queues so that software can reclaim them.

A policy bit in the packet descriptor selects between two reclamation schemes. With the bit clear, the packet descriptor pointer alone goes back, once the packet length has been sent. With the bit set, each buffer descriptor is handed back to its own queue as soon as its buffer is drained. The walk then carries on to the null pointer even after the length is used up, and the packet descriptor is returned last.

There are three streaming edges. On the transmit queue, a pop happens on `txq_valid && txq_ready`. On the byte output, a byte transfers on `tx_valid && tx_ready`; while `tx_ready` is low the engine holds `tx_valid` and `tx_data` unchanged. On the return push port, a push happens on `ret_valid && ret_ready`; `ret_ptr` and `ret_qnum` stay put until it is accepted. Memory reads are a held request: `rd_req` and `rd_addr` stay constant until the cycle in which `rd_rsp_valid` is high, and `rd_rsp_data` is taken in that cycle. Every stall freezes all engine state.

Top module: `txdesc_dma`

## Requirements
- R1: After reset the engine is idle: `txq_ready` is 1, and `tx_valid`, `ret_valid` and `rd_req` are 0.
- R2: After a pop of pointer P, the first four memory reads are at word addresses P, P+1, P+2 and P+3, in that order.
- R3: Descriptor layout. Word 0 bits 15:0 hold the packet length. Word 1 holds the byte address of the buffer. Word 2 holds the buffer length in bits 31:16, the policy in bit 15 and the return queue in bits 3:0. Word 3 holds the word address of the next descriptor, and 0 means none. A buffer descriptor is read from word 1 to word 3; its word 0 and its bit 15 are ignored.
- R4: Bytes are sent in chain order and buffer order. The byte at byte address B is bits 8*(B mod 4)+7 : 8*(B mod 4) of memory word B/4.
- R5: Exactly min(packet length, total chain bytes) bytes are sent. Buffer bytes past the packet length are never sent.
- R6: With the policy bit clear, only one push happens per packet: the packet descriptor pointer with the packet descriptor's queue, after the last byte.
- R7: With the policy bit set, each buffer descriptor pointer is pushed with the queue from its own word 2, after its buffer is drained, in chain order.
- R8: With the policy bit set, buffer descriptors beyond the point where the length runs out are still visited and returned, up to the null pointer.
- R9: With the policy bit set, the packet descriptor pointer is the final push of the packet.
- R10: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` stays 1 and `tx_data` is unchanged in the next cycle.
- R11: While `ret_valid` is 1 and `ret_ready` is 0, `ret_valid`, `ret_ptr` and `ret_qnum` are unchanged in the next cycle.
- R12: While `rd_req` is 1 and `rd_rsp_valid` is 0, `rd_req` stays 1 and `rd_addr` is unchanged in the next cycle.
- R13: `txq_ready` stays 0 from a pop until the packet descriptor of that packet has been pushed back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txq_valid | input | 1 | Transmit queue holds a packet pointer |
| txq_ptr | input | AW | Packet descriptor word address |
| txq_ready | output | 1 | Engine takes a pointer this cycle |
| rd_req | output | 1 | Memory read request, held until answered |
| rd_addr | output | AW | Memory word address |
| rd_rsp_valid | input | 1 | Read data is valid this cycle |
| rd_rsp_data | input | 32 | Read data word |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_ready | input | 1 | Sink accepts the byte |
| ret_valid | output | 1 | Return push valid |
| ret_ptr | output | AW | Descriptor pointer being returned |
| ret_qnum | output | 4 | Return queue number |
| ret_ready | input | 1 | Return queue accepts the push |

## Verification
The assertions watch, on every cycle, the hold rules of the three stalled edges (R10, R11, R12). They also check that the queue is not popped while a packet is in flight (R13) and that no byte is offered once the packet length taken from word 0 has been sent (R5). Which bytes come out, which descriptors are returned, to which queues and in what order depend on the contents of the chain. Only the bench's sweep over both policies, chain lengths of one to three buffers, packet lengths that cut the chain at several points, ready patterns and memory latencies can show them (R2 to R4, R6 to R9).

// File: rtl/txd_pkg.sv
package txd_pkg;

  localparam int DATA_W     = 32;
  localparam int LEN_W      = 16;
  localparam int BLEN_LSB   = 16;
  localparam int POLICY_BIT = 15;
  localparam int QN_W       = 4;
  localparam int BYTE_W     = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DESC,
    S_CHECK,
    S_BYTE,
    S_SEND,
    S_BDRET,
    S_NEXT,
    S_PDRET
  } txd_state_e;

  function automatic logic [LEN_W-1:0] word_blen(input logic [DATA_W-1:0] w);
    return w[BLEN_LSB +: LEN_W];
  endfunction

  function automatic logic word_policy(input logic [DATA_W-1:0] w);
    return w[POLICY_BIT];
  endfunction

  function automatic logic [QN_W-1:0] word_qnum(input logic [DATA_W-1:0] w);
    return w[QN_W-1:0];
  endfunction

endpackage

// File: rtl/txd_walker.sv
module txd_walker
  import txd_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          txq_valid,
  input  logic [AW-1:0] txq_ptr,
  input  logic          rd_rsp_valid,
  input  logic          tx_ready,
  input  logic          ret_ready,
  input  logic          buf_empty,
  input  logic          pkt_empty,
  input  logic          next_null,
  input  logic          policy,
  input  logic [AW-1:0] next_ptr,
  output txd_state_e    state,
  output logic [1:0]    widx,
  output logic          first,
  output logic [AW-1:0] cur_ptr,
  output logic [AW-1:0] pd_ptr,
  output logic          cap_en,
  output logic          byte_ld,
  output logic          byte_adv
);

  logic finish_pkt;

  assign cap_en     = (state == S_DESC) && rd_rsp_valid;
  assign byte_ld    = (state == S_BYTE) && rd_rsp_valid;
  assign byte_adv   = (state == S_SEND) && tx_ready;
  assign finish_pkt = next_null || (!policy && pkt_empty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      widx    <= 2'd0;
      first   <= 1'b0;
      cur_ptr <= '0;
      pd_ptr  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (txq_valid) begin
            pd_ptr  <= txq_ptr;
            cur_ptr <= txq_ptr;
            widx    <= 2'd0;
            first   <= 1'b1;
            state   <= S_DESC;
          end
        end
        S_DESC: begin
          if (rd_rsp_valid) begin
            if (widx == 2'd3) state <= S_CHECK;
            else              widx  <= widx + 2'd1;
          end
        end
        S_CHECK: begin
          if (!pkt_empty && !buf_empty) state <= S_BYTE;
          else if (policy && !first)    state <= S_BDRET;
          else                          state <= S_NEXT;
        end
        S_BYTE: begin
          if (rd_rsp_valid) state <= S_SEND;
        end
        S_SEND: begin
          if (tx_ready) state <= S_CHECK;
        end
        S_BDRET: begin
          if (ret_ready) state <= S_NEXT;
        end
        S_NEXT: begin
          if (finish_pkt) begin
            state <= S_PDRET;
          end else begin
            cur_ptr <= next_ptr;
            widx    <= 2'd1;
            first   <= 1'b0;
            state   <= S_DESC;
          end
        end
        S_PDRET: begin
          if (ret_ready) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/txd_fields.sv
module txd_fields
  import txd_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [1:0]        widx,
  input  logic              first,
  input  logic [DATA_W-1:0] rdata,
  output logic [LEN_W-1:0]  blen,
  output logic              policy,
  output logic [QN_W-1:0]   pd_qnum,
  output logic [QN_W-1:0]   bd_qnum,
  output logic [AW-1:0]     next_ptr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blen     <= '0;
      policy   <= 1'b0;
      pd_qnum  <= '0;
      bd_qnum  <= '0;
      next_ptr <= '0;
    end else if (cap_en) begin
      case (widx)
        2'd2: begin
          blen    <= word_blen(rdata);
          bd_qnum <= word_qnum(rdata);
          if (first) begin
            policy  <= word_policy(rdata);
            pd_qnum <= word_qnum(rdata);
          end
        end
        2'd3: next_ptr <= rdata[AW-1:0];
        default: ;
      endcase
    end
  end

  logic unused_fld;
  assign unused_fld = ^rdata;

endmodule

// File: rtl/txd_cursor.sv
module txd_cursor
  import txd_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [1:0]        widx,
  input  logic              first,
  input  logic              byte_ld,
  input  logic              byte_adv,
  input  logic [DATA_W-1:0] rdata,
  input  logic [LEN_W-1:0]  blen,
  output logic [BYTE_W-1:0] tx_byte,
  output logic [AW+1:0]     bptr,
  output logic              buf_empty,
  output logic              pkt_empty
);

  localparam int LANES = DATA_W / BYTE_W;

  logic [LEN_W-1:0]  pkt_rem;
  logic [LEN_W-1:0]  bcnt;
  logic [BYTE_W-1:0] lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = rdata[g*BYTE_W +: BYTE_W];
  end

  assign buf_empty = (bcnt == blen);
  assign pkt_empty = (pkt_rem == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_rem <= '0;
      bcnt    <= '0;
      bptr    <= '0;
      tx_byte <= '0;
    end else begin
      if (cap_en && first && widx == 2'd0) pkt_rem <= rdata[LEN_W-1:0];
      if (cap_en && widx == 2'd1) begin
        bptr <= rdata[AW+1:0];
        bcnt <= '0;
      end
      if (byte_ld) tx_byte <= lane[bptr[1:0]];
      if (byte_adv) begin
        bptr    <= bptr + 1'b1;
        bcnt    <= bcnt + 1'b1;
        pkt_rem <= pkt_rem - 1'b1;
      end
    end
  end

endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma
  import txd_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          txq_valid,
  input  logic [AW-1:0] txq_ptr,
  output logic          txq_ready,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_rsp_valid,
  input  logic [31:0]   rd_rsp_data,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  input  logic          tx_ready,
  output logic          ret_valid,
  output logic [AW-1:0] ret_ptr,
  output logic [3:0]    ret_qnum,
  input  logic          ret_ready
);

  txd_state_e       st;
  logic [1:0]       widx;
  logic             first;
  logic [AW-1:0]    cur_ptr;
  logic [AW-1:0]    pd_ptr;
  logic             cap_en;
  logic             byte_ld;
  logic             byte_adv;
  logic [LEN_W-1:0] blen;
  logic             policy;
  logic [QN_W-1:0]  pd_qnum;
  logic [QN_W-1:0]  bd_qnum;
  logic [AW-1:0]    next_ptr;
  logic [AW+1:0]    bptr;
  logic             buf_empty;
  logic             pkt_empty;
  logic [7:0]       tx_byte;

  txd_walker #(.AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_n), .txq_valid(txq_valid), .txq_ptr(txq_ptr),
    .rd_rsp_valid(rd_rsp_valid), .tx_ready(tx_ready), .ret_ready(ret_ready),
    .buf_empty(buf_empty), .pkt_empty(pkt_empty), .next_null(next_ptr == '0),
    .policy(policy), .next_ptr(next_ptr), .state(st), .widx(widx),
    .first(first), .cur_ptr(cur_ptr), .pd_ptr(pd_ptr), .cap_en(cap_en),
    .byte_ld(byte_ld), .byte_adv(byte_adv)
  );

  txd_fields #(.AW(AW)) u_fld (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .widx(widx), .first(first),
    .rdata(rd_rsp_data), .blen(blen), .policy(policy), .pd_qnum(pd_qnum),
    .bd_qnum(bd_qnum), .next_ptr(next_ptr)
  );

  txd_cursor #(.AW(AW)) u_cur (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .widx(widx), .first(first),
    .byte_ld(byte_ld), .byte_adv(byte_adv), .rdata(rd_rsp_data), .blen(blen),
    .tx_byte(tx_byte), .bptr(bptr), .buf_empty(buf_empty), .pkt_empty(pkt_empty)
  );

  assign txq_ready = (st == S_IDLE);
  assign rd_req    = (st == S_DESC) || (st == S_BYTE);
  assign rd_addr   = (st == S_DESC) ? (cur_ptr + {{(AW-2){1'b0}}, widx}) : bptr[AW+1:2];
  assign tx_valid  = (st == S_SEND);
  assign tx_data   = tx_byte;
  assign ret_valid = (st == S_BDRET) || (st == S_PDRET);
  assign ret_ptr   = (st == S_PDRET) ? pd_ptr : cur_ptr;
  assign ret_qnum  = (st == S_PDRET) ? pd_qnum : bd_qnum;

endmodule

// File: rtl/txd_chk.sv
module txd_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          txq_valid,
  input logic [AW-1:0] txq_ptr,
  input logic          txq_ready,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_rsp_valid,
  input logic [31:0]   rd_rsp_data,
  input logic          tx_valid,
  input logic [7:0]    tx_data,
  input logic          tx_ready,
  input logic          ret_valid,
  input logic [AW-1:0] ret_ptr,
  input logic [3:0]    ret_qnum,
  input logic          ret_ready
);

  logic          want_len;
  logic [15:0]   len_q;
  logic [15:0]   sent;
  logic          busy;
  logic [AW-1:0] busy_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_len <= 1'b0;
      len_q    <= '0;
      sent     <= '0;
      busy     <= 1'b0;
      busy_ptr <= '0;
    end else begin
      if (txq_valid && txq_ready) begin
        want_len <= 1'b1;
        sent     <= '0;
        busy     <= 1'b1;
        busy_ptr <= txq_ptr;
      end
      if (want_len && rd_req && rd_rsp_valid) begin
        len_q    <= rd_rsp_data[15:0];
        want_len <= 1'b0;
      end
      if (tx_valid && tx_ready) sent <= sent + 16'd1;
      if (busy && ret_valid && ret_ready && ret_ptr == busy_ptr) busy <= 1'b0;
    end
  end

  logic unused_chk;
  assign unused_chk = ^rd_rsp_data[31:16];

  // R10
  a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R11
  a_r11_ret_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && !ret_ready |=> ret_valid && $stable(ret_ptr) && $stable(ret_qnum));

  // R12
  a_r12_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_rsp_valid |=> rd_req && $stable(rd_addr));

  // R13
  a_r13_no_pop_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !txq_ready);

  // R5
  a_r5_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (!want_len && sent < len_q));

endmodule

bind txdesc_dma txd_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_txdesc_dma.sv
module sim_txdesc_dma;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int PD = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          txq_valid = 1'b0;
  logic [AW-1:0] txq_ptr = '0;
  logic          txq_ready;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_rsp_valid;
  logic [31:0]   rd_rsp_data;
  logic          tx_valid;
  logic [7:0]    tx_data;
  logic          tx_ready = 1'b1;
  logic          ret_valid;
  logic [AW-1:0] ret_ptr;
  logic [3:0]    ret_qnum;
  logic          ret_ready = 1'b1;

  txdesc_dma #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .txq_valid(txq_valid), .txq_ptr(txq_ptr),
    .txq_ready(txq_ready), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .ret_valid(ret_valid),
    .ret_ptr(ret_ptr), .ret_qnum(ret_qnum), .ret_ready(ret_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bval(input int b);
    return 8'((b * 37 + 11) & 255);
  endfunction

  // memory model: answers a held request after lat extra cycles
  logic [31:0] mem [0:1023];
  int lat = 0;
  int lcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_rsp_valid <= 1'b0;
      rd_rsp_data  <= '0;
      lcnt         <= 0;
    end else if (rd_req && !rd_rsp_valid) begin
      if (lcnt >= lat) begin
        rd_rsp_valid <= 1'b1;
        rd_rsp_data  <= mem[rd_addr];
        lcnt         <= 0;
      end else lcnt <= lcnt + 1;
    end else rd_rsp_valid <= 1'b0;
  end

  int rmode = 0;
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    tx_ready  = (rmode == 0) || (cyc % 3 != 1);
    ret_ready = (rmode == 0) || (cyc % 2 == 0);
  end

  // monitor
  logic [7:0]    got [0:63];
  int            gn = 0;
  int            rp [0:7];
  int            rq [0:7];
  int            rn = 0;
  bit            pd_seen = 0;
  bit            busy = 0;
  int            rd_k = 0;
  bit            p_tx = 0, p_ret = 0, p_rd = 0;
  logic [7:0]    p_txd;
  logic [AW-1:0] p_rp, p_ra;
  logic [3:0]    p_rq;

  always @(posedge clk) begin
    if (rst_n) begin
      if (p_tx)  check(tx_valid && tx_data == p_txd, "R10", int'(tx_data), int'(p_txd));
      if (p_ret) check(ret_valid && ret_ptr == p_rp && ret_qnum == p_rq, "R11",
                       int'(ret_ptr), int'(p_rp));
      if (p_rd)  check(rd_req && rd_addr == p_ra, "R12", int'(rd_addr), int'(p_ra));
      if (busy)  check(!txq_ready, "R13", int'(txq_ready), 0);
      p_tx = tx_valid && !tx_ready;   p_txd = tx_data;
      p_ret = ret_valid && !ret_ready; p_rp = ret_ptr; p_rq = ret_qnum;
      p_rd = rd_req && !rd_rsp_valid; p_ra = rd_addr;
      if (txq_valid && txq_ready) begin
        busy = 1; rd_k = 0;
      end
      if (rd_req && rd_rsp_valid) begin
        if (rd_k < 4) check(int'(rd_addr) == PD + rd_k, "R2", int'(rd_addr), PD + rd_k);
        rd_k++;
      end
      if (tx_valid && tx_ready && gn < 64) begin
        got[gn] = tx_data; gn++;
      end
      if (ret_valid && ret_ready) begin
        if (rn < 8) begin
          rp[rn] = int'(ret_ptr); rq[rn] = int'(ret_qnum);
        end
        rn++;
        if (int'(ret_ptr) == PD) begin
          pd_seen = 1; busy = 0;
        end
      end
    end
  end

  task automatic run_pkt(input int pol, input int n, input int psel, input int rm, input int lt);
    int len [3];
    int bp [3];
    int dp [3];
    int total, plen, en, ern, k;
    logic [7:0] eb [0:63];
    int erp [0:7];
    int erq [0:7];
    total = 0;
    for (int i = 0; i < 3; i++) begin
      dp[i]  = PD + 12 * i;
      bp[i]  = 2048 + 64 * i + ((i + n + psel) % 4);
      len[i] = 2 + ((3 * i + n + psel) % 4);
      if (i < n) total += len[i];
    end
    plen = (psel == 0) ? len[0] : (psel == 1) ? total - 1 : (psel == 2) ? total : total + 3;
    // R3 layout: word0 len, word1 buffer byte address, word2 {blen,policy,qnum}, word3 next
    for (int i = 0; i < n; i++) begin
      mem[dp[i]]     = (i == 0) ? 32'(plen) : 32'h0000_FFFF;
      mem[dp[i] + 1] = 32'(bp[i]);
      mem[dp[i] + 2] = (32'(len[i]) << 16) | (32'((i == 0) ? pol : 1 - pol) << 15)
                       | 32'((i == 0) ? 5 : 9 + i);
      mem[dp[i] + 3] = (i < n - 1) ? 32'(dp[i + 1]) : 32'd0;
    end
    en = 0;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < len[i]; j++)
        if (en < plen) begin
          eb[en] = bval(bp[i] + j); en++;
        end
    ern = 0;
    if (pol == 1)
      for (int i = 1; i < n; i++) begin
        erp[ern] = dp[i]; erq[ern] = 9 + i; ern++;
      end
    erp[ern] = PD; erq[ern] = 5; ern++;

    rmode = rm; lat = lt;
    gn = 0; rn = 0; pd_seen = 0;
    @(negedge clk);
    txq_valid = 1'b1; txq_ptr = AW'(PD);
    while (!txq_ready) @(negedge clk);
    @(negedge clk);
    txq_valid = 1'b0;
    k = 0;
    while (!pd_seen && k < 5000) begin
      @(negedge clk); k++;
    end
    check(pd_seen, "R6 packet completion", int'(pd_seen), 1);
    repeat (3) @(negedge clk);

    check(gn == en, "R5 byte count", gn, en);
    for (int i = 0; i < en && i < gn; i++)
      check(got[i] == eb[i], "R4 byte value", int'(got[i]), int'(eb[i]));
    check(rn == ern, pol ? "R7 push count" : "R6 push count", rn, ern);
    for (int i = 0; i < ern && i < rn; i++) begin
      if (i == ern - 1 && pol == 1)
        check(rp[i] == erp[i] && rq[i] == erq[i], "R9 final push", rp[i], erp[i]);
      else if (pol == 1 && psel == 0)
        check(rp[i] == erp[i] && rq[i] == erq[i], "R8 trailing return", rp[i], erp[i]);
      else if (pol == 1)
        check(rp[i] == erp[i] && rq[i] == erq[i], "R7 buffer return", rp[i], erp[i]);
      else
        check(rp[i] == erp[i] && rq[i] == erq[i], "R6 packet return", rp[i], erp[i]);
    end
  endtask

  initial begin
    for (int w = 0; w < 1024; w++)
      mem[w] = {bval(4*w+3), bval(4*w+2), bval(4*w+1), bval(4*w)};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(txq_ready == 1'b1, "R1 txq_ready", int'(txq_ready), 1);
    check(!tx_valid, "R1 tx_valid", int'(tx_valid), 0);
    check(!ret_valid, "R1 ret_valid", int'(ret_valid), 0);
    check(!rd_req, "R1 rd_req", int'(rd_req), 0);
    for (int pol = 0; pol < 2; pol++)
      for (int n = 1; n <= 3; n++)
        for (int psel = 0; psel < 4; psel++)
          run_pkt(pol, n, psel, (n + psel) % 2, (pol + psel) % 3);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule